// File: doc/BRIEF.md
# Bus Arbiter Command Channel

This block is a single memory-mapped command channel. A host uses it to launch one transaction at a time on a serial peripheral bus. The host first loads up to eight bytes of outgoing data into two 32-bit data words. It then writes a command word, which names an operation code, a target slave, a 16-bit register address and a byte count. That command write starts the transaction. The channel hands the transaction to a back-end bus engine over a valid/ready request. It then waits for a single response cycle that carries a 2-bit result code and up to eight returned bytes.

When the response arrives, the channel records the outcome in a status register that software can poll. Read-class operations place the returned bytes, least significant byte first, into two read-data words, but only when the result is success. Command writes that arrive while a transaction is still in flight are refused. A sticky overrun bit reports each such refusal. The channel handles register decode, command field extraction, byte-lane masking, status reporting and busy protection. It does not drive the serial wires and does not arbitrate between several channels.

Top module: `cmd_channel`

## Requirements
- R1: After reset, status, all data words and the last-command readback are zero, and `be_req_valid` is low.
- R2: Byte offset 0x10 holds write-data word 0 and offset 0x14 holds write-data word 1, both writable and readable. Offset 0x04 (config), 0x0C and every other unmapped offset read as zero, and writes to them have no effect.
- R3: A write to offset 0x00 while idle is accepted. From the next cycle, `be_req_valid` is high and the request shows opcode = bits 31:27, slave = bits 23:20, address = bits 19:4 and count = bits 2:0 of the written word. Offset 0x00 reads back the last accepted word.
- R4: While `be_req_valid` is high and `be_req_ready` is low, the request stays valid and every request field holds its value.
- R5: Write-class opcodes 0, 2, 9, 14 and 16 carry the data words as a 64-bit value with word 0 in bits 31:0, byte lane i in bits 8i+7:8i. Lanes above the count are zeroed. All other opcodes carry zero data.
- R6: Status is bit 0 done, bit 1 failure, bit 2 denied, bit 3 dropped, bit 4 overrun and bit 5 busy. A response sets done and clears busy. Result code 0 (success) sets no error bit, code 1 sets bit 1, code 2 sets bit 2 and code 3 sets bit 3. An error bit is never set without done.
- R7: Read-class opcodes 1, 8, 13 and 15 update the read-data words at offsets 0x18 (lanes 0–3) and 0x1C (lanes 4–7) from the response data, with lanes above the count zeroed, and only when the result is success. Errors and all other opcodes leave them unchanged.
- R8: A command write while busy is ignored: the request in flight is unchanged and status bit 4 is set and stays set.
- R9: Accepting a new command clears done, all error bits and the overrun bit.
- R10: Writes to the status offset 0x08 and to the read-data offsets 0x18 and 0x1C have no effect.
- R11: A response cycle that arrives while no request has been handed over is ignored.
- R12: The write data of a transaction is captured when its command is accepted. Writes to the data words after that do not alter the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_addr | input | 5 | Host byte offset within the channel |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Register readback for `bus_addr` (combinational) |
| be_req_valid | output | 1 | Request to the back-end is valid |
| be_req_ready | input | 1 | Back-end takes the request |
| be_req_opcode | output | 5 | Request operation code |
| be_req_sid | output | 4 | Request slave identifier |
| be_req_addr | output | 16 | Request register address |
| be_req_count | output | 3 | Request byte count minus one |
| be_req_wdata | output | 64 | Request write bytes, lane 0 in bits 7:0 |
| be_rsp_valid | input | 1 | Back-end response cycle |
| be_rsp_result | input | 2 | Result: 0 ok, 1 failure, 2 denied, 3 dropped |
| be_rsp_rdata | input | 64 | Returned bytes, lane 0 in bits 7:0 |

## Verification
The bench targets the following cases:
- A command write that lands during the request phase and one that lands during the response wait. A design that forwards such a write would corrupt the request on the back-end port or lose the overrun flag.
- Data-word rewrites while a request is stalled. A design that reads the live data words instead of a snapshot would show changing write data.
- Short byte counts and non-data opcodes. Leaking lanes would appear as stale bytes.
- Every error code on a read operation. A design that updates read data on failure, or that mixes up the error bit positions, would show up directly in the readback.
- Stray response cycles while idle and while the request is still unacknowledged. A design that records them would set done early or overwrite read data.

// File: rtl/cmd_chan_pkg.sv
// Shared definitions for the command channel: register offsets, command
// field layout, operation codes, result codes and opcode classification.
// Assumes a 32-bit host register word and a 5-bit byte offset space.
package cmd_chan_pkg;

    localparam int OFFS_W = 5;

    localparam logic [OFFS_W-1:0] OFF_CMD  = 5'h00;
    localparam logic [OFFS_W-1:0] OFF_CFG  = 5'h04;
    localparam logic [OFFS_W-1:0] OFF_STAT = 5'h08;
    localparam logic [OFFS_W-1:0] OFF_WD0  = 5'h10;
    localparam logic [OFFS_W-1:0] OFF_WD1  = 5'h14;
    localparam logic [OFFS_W-1:0] OFF_RD0  = 5'h18;
    localparam logic [OFFS_W-1:0] OFF_RD1  = 5'h1C;

    // Status bit positions
    localparam int ST_DONE = 0;
    localparam int ST_FAIL = 1;
    localparam int ST_DENY = 2;
    localparam int ST_DROP = 3;
    localparam int ST_OVR  = 4;
    localparam int ST_BUSY = 5;
    localparam int ST_W    = 6;

    typedef enum logic [4:0] {
        OPC_EXT_WR_LONG = 5'd0,
        OPC_EXT_RD_LONG = 5'd1,
        OPC_EXT_WR      = 5'd2,
        OPC_RESET       = 5'd3,
        OPC_SLEEP       = 5'd4,
        OPC_SHUTDOWN    = 5'd5,
        OPC_WAKEUP      = 5'd6,
        OPC_AUTH        = 5'd7,
        OPC_MST_RD      = 5'd8,
        OPC_MST_WR      = 5'd9,
        OPC_EXT_RD      = 5'd13,
        OPC_WR          = 5'd14,
        OPC_RD          = 5'd15,
        OPC_ZERO_WR     = 5'd16
    } opcode_e;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_FAIL = 2'd1,
        RES_DENY = 2'd2,
        RES_DROP = 2'd3
    } result_e;

    // Decoded command word
    typedef struct packed {
        logic [4:0]  opc;
        logic [3:0]  sid;
        logic [15:0] addr;
        logic [2:0]  cnt;
    } cmd_t;

    // Operations that return bytes from the target
    function automatic logic op_reads(input logic [4:0] op);
        case (op)
            OPC_EXT_RD_LONG, OPC_MST_RD, OPC_EXT_RD, OPC_RD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Operations that carry bytes to the target
    function automatic logic op_writes(input logic [4:0] op);
        case (op)
            OPC_EXT_WR_LONG, OPC_EXT_WR, OPC_MST_WR, OPC_WR, OPC_ZERO_WR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmd_chan_bytemask.sv
// Keeps byte lanes 0..last of a multi-byte value and zeroes the lanes above.
// Assumes LANES is a power of two so that 'last' addresses every lane.
module cmd_chan_bytemask #(
    parameter int LANES = 8
) (
    input  logic [LANES*8-1:0]         din,
    input  logic [$clog2(LANES)-1:0]   last,
    output logic [LANES*8-1:0]         dout
);
    localparam int CNT_W = $clog2(LANES);

    // One comparator per lane selects data or zero
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [CNT_W-1:0] LANE_IDX = CNT_W'(g);
        assign dout[g*8 +: 8] = (LANE_IDX <= last) ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/cmd_chan_ctrl.sv
// Transaction sequencer: accepts a command while idle, presents it to the
// back-end until taken, waits for the response and records the outcome.
// Assumes exactly one response cycle per accepted request.
module cmd_chan_ctrl
    import cmd_chan_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  cmd_t               cmd_in,
    input  logic [DATA_W-1:0]  wdata_masked,
    output logic               cmd_load,
    output logic               req_valid,
    input  logic               req_ready,
    output cmd_t               req_cmd,
    output logic [DATA_W-1:0]  req_data,
    input  logic               rsp_valid,
    input  logic [1:0]         rsp_result,
    output logic               rd_load,
    output logic [ST_W-1:0]    status
);
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_e;

    state_e             state_q;
    cmd_t               cmd_q;
    logic [DATA_W-1:0]  data_q;
    logic               done_q, fail_q, deny_q, drop_q, ovr_q;
    logic               rsp_take;

    assign cmd_load  = cmd_wr && (state_q == S_IDLE);
    assign rsp_take  = (state_q == S_WAIT) && rsp_valid;
    assign rd_load   = rsp_take && (rsp_result == RES_OK) && op_reads(cmd_q.opc);
    assign req_valid = (state_q == S_REQ);
    assign req_cmd   = cmd_q;
    assign req_data  = data_q;

    // Sequencer state: idle -> request -> wait -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE:  if (cmd_load)  state_q <= S_REQ;
                S_REQ:   if (req_ready) state_q <= S_WAIT;
                S_WAIT:  if (rsp_valid) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Snapshot of the command and its outgoing bytes at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (cmd_load) begin
            cmd_q  <= cmd_in;
            data_q <= op_writes(cmd_in.opc) ? wdata_masked : '0;
        end
    end

    // Completion, error and overrun flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            deny_q <= 1'b0;
            drop_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (cmd_load) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            deny_q <= 1'b0;
            drop_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (cmd_wr) begin
                ovr_q <= 1'b1;
            end
            if (rsp_take) begin
                done_q <= 1'b1;
                fail_q <= (rsp_result == RES_FAIL);
                deny_q <= (rsp_result == RES_DENY);
                drop_q <= (rsp_result == RES_DROP);
            end
        end
    end

    // Status vector assembly
    always_comb begin
        status          = '0;
        status[ST_DONE] = done_q;
        status[ST_FAIL] = fail_q;
        status[ST_DENY] = deny_q;
        status[ST_DROP] = drop_q;
        status[ST_OVR]  = ovr_q;
        status[ST_BUSY] = (state_q != S_IDLE);
    end
endmodule

// File: rtl/cmd_chan_regs.sv
// Host-visible register file: write-data words, read-data words, last
// accepted command word and the readback multiplexer.
// Assumes one host access per cycle; reads are combinational.
module cmd_chan_regs
    import cmd_chan_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [OFFS_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic                 cmd_load,
    input  logic                 rd_load,
    input  logic [2*WORD_W-1:0]  rd_value,
    input  logic [ST_W-1:0]      status,
    output logic [2*WORD_W-1:0]  wd_words,
    output logic [WORD_W-1:0]    bus_rdata
);
    logic [WORD_W-1:0] wd0_q, wd1_q, rd0_q, rd1_q, cmd_q;

    assign wd_words = {wd1_q, wd0_q};

    // Host-loaded outgoing data words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd0_q <= '0;
            wd1_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_WD0) wd0_q <= bus_wdata;
            if (bus_addr == OFF_WD1) wd1_q <= bus_wdata;
        end
    end

    // Last accepted command word for readback
    always_ff @(posedge clk) begin
        if (!rst_n)        cmd_q <= '0;
        else if (cmd_load) cmd_q <= bus_wdata;
    end

    // Returned bytes, loaded only on a successful read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd0_q <= '0;
            rd1_q <= '0;
        end else if (rd_load) begin
            rd0_q <= rd_value[WORD_W-1:0];
            rd1_q <= rd_value[2*WORD_W-1:WORD_W];
        end
    end

    // Readback multiplexer; unmapped offsets and config read zero
    always_comb begin
        case (bus_addr)
            OFF_CMD:  bus_rdata = cmd_q;
            OFF_STAT: bus_rdata = {{(WORD_W-ST_W){1'b0}}, status};
            OFF_WD0:  bus_rdata = wd0_q;
            OFF_WD1:  bus_rdata = wd1_q;
            OFF_RD0:  bus_rdata = rd0_q;
            OFF_RD1:  bus_rdata = rd1_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmd_channel.sv
// Top of the command channel: splits the command word into fields, masks
// outgoing and returned bytes to the byte count, and joins the register
// file with the sequencer. Assumes WORD_W is 32 (command layout is fixed).
module cmd_channel
    import cmd_chan_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [4:0]           bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 be_req_valid,
    input  logic                 be_req_ready,
    output logic [4:0]           be_req_opcode,
    output logic [3:0]           be_req_sid,
    output logic [15:0]          be_req_addr,
    output logic [2:0]           be_req_count,
    output logic [2*WORD_W-1:0]  be_req_wdata,
    input  logic                 be_rsp_valid,
    input  logic [1:0]           be_rsp_result,
    input  logic [2*WORD_W-1:0]  be_rsp_rdata
);
    localparam int DATA_W = 2 * WORD_W;
    localparam int LANES  = DATA_W / 8;

    logic               cmd_wr, cmd_load, rd_load;
    cmd_t               cmd_in, req_cmd;
    logic [DATA_W-1:0]  wd_words, wd_masked, rd_masked;
    logic [ST_W-1:0]    chan_status;

    // Command field extraction from the host word
    assign cmd_wr      = bus_wr && (bus_addr == OFF_CMD);
    assign cmd_in.opc  = bus_wdata[31:27];
    assign cmd_in.sid  = bus_wdata[23:20];
    assign cmd_in.addr = bus_wdata[19:4];
    assign cmd_in.cnt  = bus_wdata[2:0];

    assign be_req_opcode = req_cmd.opc;
    assign be_req_sid    = req_cmd.sid;
    assign be_req_addr   = req_cmd.addr;
    assign be_req_count  = req_cmd.cnt;

    cmd_chan_regs #(.WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd_load  (cmd_load),
        .rd_load   (rd_load),
        .rd_value  (rd_masked),
        .status    (chan_status),
        .wd_words  (wd_words),
        .bus_rdata (bus_rdata)
    );

    cmd_chan_bytemask #(.LANES(LANES)) u_wmask (
        .din  (wd_words),
        .last (cmd_in.cnt),
        .dout (wd_masked)
    );

    cmd_chan_bytemask #(.LANES(LANES)) u_rmask (
        .din  (be_rsp_rdata),
        .last (req_cmd.cnt),
        .dout (rd_masked)
    );

    cmd_chan_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_in       (cmd_in),
        .wdata_masked (wd_masked),
        .cmd_load     (cmd_load),
        .req_valid    (be_req_valid),
        .req_ready    (be_req_ready),
        .req_cmd      (req_cmd),
        .req_data     (be_req_wdata),
        .rsp_valid    (be_rsp_valid),
        .rsp_result   (be_rsp_result),
        .rd_load      (rd_load),
        .status       (chan_status)
    );
endmodule

// File: rtl/cmd_channel_chk.sv
// Protocol and status checker for cmd_channel, attached by bind.
// Assumes the default 64-bit request data width.
module cmd_channel_chk #(
    parameter int DATA_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [4:0]         bus_addr,
    input logic               be_req_valid,
    input logic               be_req_ready,
    input logic [4:0]         be_req_opcode,
    input logic [3:0]         be_req_sid,
    input logic [15:0]        be_req_addr,
    input logic [2:0]         be_req_count,
    input logic [DATA_W-1:0]  be_req_wdata,
    input logic               be_rsp_valid,
    input logic [5:0]         chan_status
);
    // R4: a stalled request keeps every field
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        be_req_valid && !be_req_ready |=> be_req_valid && $stable(be_req_opcode)
        && $stable(be_req_sid) && $stable(be_req_addr) && $stable(be_req_count)
        && $stable(be_req_wdata));

    // R3: a request only starts after a command-offset write
    a_r3_req_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_req_valid) |-> $past(bus_wr && bus_addr == 5'h00));

    // R9: a freshly accepted command shows no old outcome flags
    a_r9_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_req_valid) |-> chan_status[4:0] == 5'd0);

    // R6: error bits only alongside done
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_status[3:1]) |-> chan_status[0]);

    // R6: a response in the wait phase completes the transaction
    a_r6_done_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        chan_status[5] && !be_req_valid && be_rsp_valid |=> chan_status[0] && !chan_status[5]);

    // R8: a request is only offered while busy
    a_r8_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        be_req_valid |-> chan_status[5]);

    // R8: a command write while busy raises overrun
    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        chan_status[5] && bus_wr && bus_addr == 5'h00 |=> chan_status[4]);
endmodule

bind cmd_channel cmd_channel_chk #(.DATA_W(2*WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .be_req_valid  (be_req_valid),
    .be_req_ready  (be_req_ready),
    .be_req_opcode (be_req_opcode),
    .be_req_sid    (be_req_sid),
    .be_req_addr   (be_req_addr),
    .be_req_count  (be_req_count),
    .be_req_wdata  (be_req_wdata),
    .be_rsp_valid  (be_rsp_valid),
    .chan_status   (chan_status)
);

// File: tb/tb_cmd_channel.sv
`timescale 1ns/100ps
// Bench for cmd_channel: behavioural reference model updated on every rising
// edge, compared against the outputs on every falling edge, plus directed checks.
module tb_cmd_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        be_req_valid;
    logic        be_req_ready = 1'b0;
    logic [4:0]  be_req_opcode;
    logic [3:0]  be_req_sid;
    logic [15:0] be_req_addr;
    logic [2:0]  be_req_count;
    logic [63:0] be_req_wdata;
    logic        be_rsp_valid = 1'b0;
    logic [1:0]  be_rsp_result = 2'd0;
    logic [63:0] be_rsp_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;
    bit ended = 1'b0;

    cmd_channel dut (.*);

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_state = 0;
    logic        m_done = 0, m_ovr = 0;
    logic [2:0]  m_err = 0;
    logic [31:0] m_wd0 = 0, m_wd1 = 0, m_rd0 = 0, m_rd1 = 0, m_cmd = 0;
    logic [63:0] m_data = 0;

    function automatic logic [63:0] mmask(input logic [63:0] d, input int bc);
        logic [63:0] r = '0;
        for (int i = 0; i <= bc; i++) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    function automatic bit mreads(input int op);
        return op == 1 || op == 8 || op == 13 || op == 15;
    endfunction

    function automatic bit mwrites(input int op);
        return op == 0 || op == 2 || op == 9 || op == 14 || op == 16;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_cmd;
            5'h08: return {26'd0, m_state != 0, m_ovr, m_err, m_done};
            5'h10: return m_wd0;
            5'h14: return m_wd1;
            5'h18: return m_rd0;
            5'h1C: return m_rd1;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_done = 0; m_ovr = 0; m_err = 0;
            m_wd0 = 0; m_wd1 = 0; m_rd0 = 0; m_rd1 = 0; m_cmd = 0; m_data = 0;
        end else begin
            int ns;
            ns = m_state;
            if (bus_wr) begin
                if (bus_addr == 5'h10) m_wd0 = bus_wdata;
                else if (bus_addr == 5'h14) m_wd1 = bus_wdata;
                else if (bus_addr == 5'h00) begin
                    if (m_state == 0) begin
                        m_cmd  = bus_wdata;
                        m_data = mwrites(int'(bus_wdata[31:27])) ?
                                 mmask({m_wd1, m_wd0}, int'(bus_wdata[2:0])) : 64'd0;
                        m_done = 0; m_err = 0; m_ovr = 0;
                        ns = 1;
                    end else begin
                        m_ovr = 1;
                    end
                end
            end
            if (m_state == 1 && be_req_ready) ns = 2;
            if (m_state == 2 && be_rsp_valid) begin
                ns = 0;
                m_done = 1;
                m_err = (be_rsp_result == 2'd1) ? 3'b001 :
                        (be_rsp_result == 2'd2) ? 3'b010 :
                        (be_rsp_result == 2'd3) ? 3'b100 : 3'b000;
                if (be_rsp_result == 2'd0 && mreads(int'(m_cmd[31:27]))) begin
                    {m_rd1, m_rd0} = mmask(be_rsp_rdata, int'(m_cmd[2:0]));
                end
            end
            m_state = ns;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            check("R3 request valid", be_req_valid, m_state == 1);
            if (m_state == 1) begin
                check("R3 request opcode", be_req_opcode, m_cmd[31:27]);
                check("R3 request slave", be_req_sid, m_cmd[23:20]);
                check("R3 request address", be_req_addr, m_cmd[19:4]);
                check("R3 request count", be_req_count, m_cmd[2:0]);
                check("R5 request data", be_req_wdata, m_data);
            end
            case (bus_addr)
                5'h08:        check("R6 status readback", bus_rdata, m_read(bus_addr));
                5'h18, 5'h1C: check("R7 read-data readback", bus_rdata, m_read(bus_addr));
                default:      check("R2 register readback", bus_rdata, m_read(bus_addr));
            endcase
        end
    end

    // ---------------- back-end responder ----------------
    int          rdy_lat = 2, rsp_lat = 1, ph = 0, cnt = 0;
    logic [1:0]  rsp_code = 2'd0;
    logic [63:0] rsp_data = '0;
    bit          spur_idle = 1'b0, spur_req = 1'b0;

    always @(negedge clk) begin
        #1;
        be_req_ready  = 1'b0;
        be_rsp_valid  = 1'b0;
        be_rsp_result = 2'd0;
        be_rsp_rdata  = '0;
        if (!rst_n) begin
            ph = 0;
        end else begin
            if (ph == 0) begin
                if (be_req_valid) begin
                    ph = 1; cnt = 0;
                end else if (spur_idle) begin
                    be_rsp_valid = 1'b1; be_rsp_result = rsp_code; be_rsp_rdata = rsp_data;
                end
            end
            if (ph == 1) begin
                if (cnt >= rdy_lat) begin
                    be_req_ready = 1'b1; ph = 2; cnt = 0;
                end else begin
                    cnt++;
                    if (spur_req) begin
                        be_rsp_valid = 1'b1; be_rsp_result = 2'd3;
                        be_rsp_rdata = 64'h5555_5555_5555_5555;
                    end
                end
            end else if (ph == 2) begin
                if (cnt >= rsp_lat) begin
                    be_rsp_valid = 1'b1; be_rsp_result = rsp_code; be_rsp_rdata = rsp_data;
                    ph = 3;
                end else begin
                    cnt++;
                end
            end else if (ph == 3) begin
                ph = 0;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mkcmd(input int op, input int sid, input int adr, input int bc);
        return {op[4:0], 3'b000, sid[3:0], adr[15:0], 1'b0, bc[2:0]};
    endfunction

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (m_state != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] c;
        logic [4:0]  h_op;
        logic [15:0] h_ad;
        logic [63:0] h_dat;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk_on = 1'b1;

        // R1: reset state
        read_chk(5'h08, 32'h0, "R1 status after reset");
        read_chk(5'h18, 32'h0, "R1 read word 0 after reset");
        read_chk(5'h1C, 32'h0, "R1 read word 1 after reset");
        read_chk(5'h00, 32'h0, "R1 command readback after reset");
        check("R1 request idle", be_req_valid, 1'b0);

        // R2: data words and reserved offsets
        bus_write(5'h10, 32'h4433_2211);
        bus_write(5'h14, 32'h8877_6655);
        bus_write(5'h04, 32'hFFFF_FFFF);
        bus_write(5'h0C, 32'hFFFF_FFFF);
        read_chk(5'h10, 32'h4433_2211, "R2 write word 0");
        read_chk(5'h14, 32'h8877_6655, "R2 write word 1");
        read_chk(5'h04, 32'h0, "R2 config reads zero");
        read_chk(5'h0C, 32'h0, "R2 unmapped reads zero");

        // R3, R5, R12: full-length write with stalled ready
        rdy_lat = 5; rsp_lat = 1; rsp_code = 2'd0; rsp_data = '0;
        c = mkcmd(14, 5, 16'h1234, 7);
        bus_write(5'h00, c);
        check("R3 valid after command", be_req_valid, 1'b1);
        check("R3 opcode field", be_req_opcode, 5'd14);
        check("R3 slave field", be_req_sid, 4'd5);
        check("R3 address field", be_req_addr, 16'h1234);
        check("R3 count field", be_req_count, 3'd7);
        check("R5 eight-byte data", be_req_wdata, 64'h8877_6655_4433_2211);
        bus_write(5'h10, 32'hDEAD_BEEF);
        check("R12 snapshot holds", be_req_wdata, 64'h8877_6655_4433_2211);
        check("R4 still waiting for ready", be_req_valid, 1'b1);
        wait_idle();
        read_chk(5'h08, 32'h01, "R6 done after success");
        read_chk(5'h00, c, "R3 command readback");

        // R4: fields stable across a long stall
        rdy_lat = 6;
        bus_write(5'h00, mkcmd(2, 9, 16'hBEEF, 3));
        h_op = be_req_opcode; h_ad = be_req_addr; h_dat = be_req_wdata;
        repeat (3) @(negedge clk);
        #1;
        check("R4 valid held", be_req_valid, 1'b1);
        check("R4 opcode held", be_req_opcode, h_op);
        check("R4 address held", be_req_addr, h_ad);
        check("R4 data held", be_req_wdata, h_dat);
        wait_idle();

        // R5: short count and non-data opcode
        rdy_lat = 2;
        bus_write(5'h00, mkcmd(0, 1, 16'h0040, 1));
        check("R5 two-byte mask", be_req_wdata, 64'h0000_0000_0000_BEEF);
        wait_idle();
        bus_write(5'h00, mkcmd(3, 2, 16'h0000, 7));
        check("R5 non-data opcode carries zero", be_req_wdata, 64'h0);
        wait_idle();

        // R7: successful reads with masking
        rsp_data = 64'hAABB_CCDD_1122_3344;
        bus_write(5'h00, mkcmd(15, 3, 16'h0100, 2));
        wait_idle();
        read_chk(5'h18, 32'h0022_3344, "R7 three-byte read word 0");
        read_chk(5'h1C, 32'h0, "R7 three-byte read word 1");
        bus_write(5'h00, mkcmd(1, 3, 16'h0200, 5));
        wait_idle();
        read_chk(5'h18, 32'h1122_3344, "R7 six-byte read word 0");
        read_chk(5'h1C, 32'h0000_CCDD, "R7 six-byte read word 1");

        // R6, R7: each error code on a read leaves read data unchanged
        rsp_data = 64'h0F0F_0F0F_0F0F_0F0F;
        for (int code = 1; code <= 3; code++) begin
            rsp_code = code[1:0];
            bus_write(5'h00, mkcmd(15, 3, 16'h0300, 7));
            wait_idle();
            read_chk(5'h08, 32'h1 | (32'h1 << code), "R6 error code bit");
            read_chk(5'h18, 32'h1122_3344, "R7 read word 0 kept on error");
        end
        rsp_code = 2'd0;
        bus_write(5'h00, mkcmd(14, 3, 16'h0300, 7));
        wait_idle();
        read_chk(5'h18, 32'h1122_3344, "R7 write op leaves read data");

        // R8, R9: overrun while busy, cleared by next accepted command
        rdy_lat = 8;
        bus_write(5'h00, mkcmd(2, 1, 16'h0010, 0));
        bus_write(5'h00, mkcmd(15, 4, 16'h0777, 7));
        read_chk(5'h08, 32'h30, "R8 busy with overrun");
        check("R8 in-flight opcode kept", be_req_opcode, 5'd2);
        check("R8 in-flight address kept", be_req_addr, 16'h0010);
        wait_idle();
        read_chk(5'h08, 32'h11, "R8 overrun sticky after done");
        rdy_lat = 2;
        bus_write(5'h00, mkcmd(14, 1, 16'h0020, 0));
        read_chk(5'h08, 32'h20, "R9 flags cleared on accept");
        wait_idle();
        read_chk(5'h08, 32'h01, "R9 done only");

        // R10: status and read-data offsets ignore writes
        bus_write(5'h08, 32'hFFFF_FFFF);
        read_chk(5'h08, 32'h01, "R10 status write ignored");
        bus_write(5'h18, 32'h0);
        bus_write(5'h1C, 32'hFFFF_FFFF);
        read_chk(5'h18, 32'h1122_3344, "R10 read word 0 write ignored");
        read_chk(5'h1C, 32'h0000_CCDD, "R10 read word 1 write ignored");

        // R11: stray responses while idle and before hand-over
        rsp_code = 2'd2; rsp_data = 64'h5555_5555_5555_5555;
        spur_idle = 1'b1;
        repeat (3) @(negedge clk);
        spur_idle = 1'b0;
        read_chk(5'h08, 32'h01, "R11 idle response ignored");
        read_chk(5'h18, 32'h1122_3344, "R11 idle response leaves data");
        rsp_code = 2'd0; rsp_data = 64'h0000_0000_9988_7766;
        rdy_lat = 3; spur_req = 1'b1;
        bus_write(5'h00, mkcmd(15, 6, 16'h0400, 3));
        read_chk(5'h08, 32'h20, "R11 early response ignored");
        wait_idle();
        spur_req = 1'b0;
        read_chk(5'h08, 32'h01, "R11 real response recorded");
        read_chk(5'h18, 32'h9988_7766, "R11 real read data");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule